// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Interrupt

This block watches for a stalled processor. A free-running counter advances on every tick of the block clock. Software must restart it by writing a fixed refresh key before the count reaches the end of its period. If the period runs out, the block raises a one-cycle reset request. A write is also treated as a fault, and raises the same request at once, in two cases: when the correct key arrives while the window is still closed, or when any other byte value is written at any time.

The block clock runs at twice the rate of the low-speed oscillator that the timer is specified against. This lets the early-warning interrupt land exactly half a low-speed cycle after the three-quarter point of the period. The period length, the fraction of the period during which a refresh is accepted, and the interrupt enable are captured from their inputs while reset is held. After that they are frozen until the next reset.

Top module: `wdt_windowed`

## Requirements
- R1: While `rst_n` is low, `irq` and `rst_req` are both 0, and the count is 0 in the first cycle after release.
- R2: With no writes, `rst_req` is high for exactly one cycle, H cycles after reset release. The count then restarts from zero, so the next pulse follows H cycles later.
- R3: A write of 0xAC while the count is at or beyond the closed limit restarts the count from zero without a reset request. This includes a write in the last cycle before overflow. The next overflow pulse then comes H+1 cycles after the write was presented.
- R4: A write of 0xAC while the count is below the closed limit gives a one-cycle `rst_req` in the next cycle, and the count restarts from zero.
- R5: A write of any value other than 0xAC gives a one-cycle `rst_req` in the next cycle, whatever the count, and the count restarts from zero.
- R6: The closed limit is chosen by `cfg_window_sel`. Encoding 2'b00 gives a 50% window, closed for counts below H/2. Encoding 2'b01 gives a 75% window, closed for counts below H/4.
- R7: Encodings 2'b10 and 2'b11 of `cfg_window_sel` give a 100% window, in which a key write is accepted at every count, including count 0.
- R8: With the interrupt enabled, `irq` is high for exactly one cycle, when the count equals 3H/4 + 1 (three quarters of the period plus half a low-speed cycle). The count keeps running afterwards and still overflows at H.
- R9: With the interrupt disabled, `irq` stays 0.
- R10: `cfg_period_sel`, `cfg_window_sel` and `cfg_irq_en` are sampled only while `rst_n` is low. Changing them after release changes neither the period, nor the window, nor the interrupt.
- R11: The period in block-clock cycles is H = 2^(BASE_EXP + `cfg_period_sel` + 1), which is 2^(BASE_EXP + `cfg_period_sel`) low-speed cycles. The count never exceeds H-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the low-speed oscillator rate |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_period_sel | input | SEL_W | Period exponent offset, captured at reset |
| cfg_window_sel | input | 2 | Open-window fraction select, captured at reset |
| cfg_irq_en | input | 1 | Early-warning interrupt enable, captured at reset |
| wr_en | input | 1 | Write strobe to the refresh register |
| wr_data | input | 8 | Byte written to the refresh register |
| irq | output | 1 | One-cycle early-warning interrupt pulse |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The count is not visible at the ports, so a wrong internal count shows up only as a pulse at the wrong time. A count that is off by one moves the `irq` pulse, and every later `rst_req` pulse, by one cycle. The bench samples on the exact cycle and on the cycles on either side of it. A wrong closed limit shows one cycle after a key write at the window boundary, as a `rst_req` that is present when it should be absent, or absent when it should be present. Configuration that is not frozen shows within one period after the inputs are changed.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Open-window fraction encodings (closed window measured from count zero)
    typedef enum logic [1:0] {
        WIN_HALF     = 2'b00,
        WIN_QUARTER  = 2'b01,
        WIN_FULL     = 2'b10,
        WIN_FULL_ALT = 2'b11
    } win_sel_e;

    // Classification of one access to the refresh register
    typedef enum logic [1:0] {
        ACT_IDLE    = 2'b00,
        ACT_REFRESH = 2'b01,
        ACT_VIOLATE = 2'b10
    } wr_act_e;

    localparam logic [7:0] DEFAULT_KEY = 8'hAC;

endpackage

// File: rtl/wdt_limits.sv
module wdt_limits
    import wdt_pkg::*;
#(
    parameter int BASE_EXP = 2,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = BASE_EXP + (1 << SEL_W)
) (
    input  logic [SEL_W-1:0] period_sel,
    input  win_sel_e         window_sel,
    output logic [CNT_W-1:0] term_cnt,
    output logic [CNT_W-1:0] closed_lim,
    output logic [CNT_W-1:0] irq_pt
);

    localparam int SPAN_W = CNT_W + 1;

    // Full period in half low-speed cycles
    logic [SPAN_W-1:0] span;

    always_comb begin
        span     = SPAN_W'(1) << (int'(period_sel) + BASE_EXP + 1);
        term_cnt = CNT_W'(span - SPAN_W'(1));
        irq_pt   = CNT_W'((span >> 1) + (span >> 2) + SPAN_W'(1));
        unique case (window_sel)
            WIN_HALF:    closed_lim = CNT_W'(span >> 1);
            WIN_QUARTER: closed_lim = CNT_W'(span >> 2);
            default:     closed_lim = '0;
        endcase
    end

endmodule

// File: rtl/wdt_key_check.sv
module wdt_key_check
    import wdt_pkg::*;
#(
    parameter int         CNT_W = 10,
    parameter logic [7:0] KEY   = DEFAULT_KEY
) (
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] closed_lim,
    output wr_act_e          act
);

    logic key_ok;
    logic open_win;

    always_comb begin
        key_ok   = (wr_data == KEY);
        open_win = (cnt >= closed_lim);
        if (!wr_en) begin
            act = ACT_IDLE;
        end else if (key_ok && open_win) begin
            act = ACT_REFRESH;
        end else begin
            act = ACT_VIOLATE;
        end
    end

endmodule

// File: rtl/wdt_windowed.sv
module wdt_windowed
    import wdt_pkg::*;
#(
    parameter int         BASE_EXP = 2,
    parameter int         SEL_W    = 3,
    parameter logic [7:0] KEY      = DEFAULT_KEY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] cfg_period_sel,
    input  logic [1:0]       cfg_window_sel,
    input  logic             cfg_irq_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             irq,
    output logic             rst_req
);

    localparam int CNT_W = BASE_EXP + (1 << SEL_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rst_req;
        logic             irq;
        logic [SEL_W-1:0] period_sel;
        win_sel_e         window_sel;
        logic             irq_en;
    } state_t;

    state_t q, d, rst_val;

    logic [CNT_W-1:0] term_cnt;
    logic [CNT_W-1:0] closed_lim;
    logic [CNT_W-1:0] irq_pt;
    wr_act_e          act;

    // Names seen by the bound checker
    logic [CNT_W-1:0] cnt_q;
    logic             irq_en_q;

    wdt_limits #(
        .BASE_EXP (BASE_EXP),
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W)
    ) u_limits (
        .period_sel (q.period_sel),
        .window_sel (q.window_sel),
        .term_cnt   (term_cnt),
        .closed_lim (closed_lim),
        .irq_pt     (irq_pt)
    );

    wdt_key_check #(
        .CNT_W (CNT_W),
        .KEY   (KEY)
    ) u_key (
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cnt        (q.cnt),
        .closed_lim (closed_lim),
        .act        (act)
    );

    always_comb begin
        // Reset image: configuration captured from the inputs
        rst_val            = '0;
        rst_val.period_sel = cfg_period_sel;
        rst_val.window_sel = win_sel_e'(cfg_window_sel);
        rst_val.irq_en     = cfg_irq_en;

        d         = q;
        d.rst_req = 1'b0;
        unique case (act)
            ACT_REFRESH: d.cnt = '0;
            ACT_VIOLATE: begin
                d.cnt     = '0;
                d.rst_req = 1'b1;
            end
            default: begin
                if (q.cnt == term_cnt) begin
                    d.cnt     = '0;
                    d.rst_req = 1'b1;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        endcase
        d.irq = q.irq_en && !d.rst_req && (d.cnt == irq_pt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= rst_val;
        end else begin
            q <= d;
        end
    end

    assign irq      = q.irq;
    assign rst_req  = q.rst_req;
    assign cnt_q    = q.cnt;
    assign irq_en_q = q.irq_en;

endmodule

// File: rtl/wdt_windowed_chk.sv
module wdt_windowed_chk #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             irq,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] term_cnt,
    input logic [CNT_W-1:0] closed_lim,
    input logic             irq_en_q
);

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !wr_en) |=> !rst_req);

    assert_restart_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt_q == '0));

    assert_good_refresh_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'hAC && cnt_q >= closed_lim) |=> (!rst_req && cnt_q == '0));

    assert_closed_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cnt_q < closed_lim) |=> rst_req);

    assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != 8'hAC) |=> rst_req);

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |-> !irq);

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= term_cnt);

endmodule

bind wdt_windowed wdt_windowed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .irq        (irq),
    .rst_req    (rst_req),
    .cnt_q      (cnt_q),
    .term_cnt   (term_cnt),
    .closed_lim (closed_lim),
    .irq_en_q   (irq_en_q)
);

// File: tb/tb_wdt_windowed.sv
module tb_wdt_windowed;

    localparam int BASE_EXP = 2;
    localparam int SEL_W    = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [SEL_W-1:0] cfg_period_sel = '0;
    logic [1:0]       cfg_window_sel = '0;
    logic             cfg_irq_en = 1'b0;
    logic             wr_en = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             irq;
    logic             rst_req;

    int checks = 0;
    int fails  = 0;

    wdt_windowed #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_period_sel (cfg_period_sel),
        .cfg_window_sel (cfg_window_sel),
        .cfg_irq_en     (cfg_irq_en),
        .wr_en          (wr_en),
        .wr_data        (wr_data),
        .irq            (irq),
        .rst_req        (rst_req)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [2:0] sel;
        logic [1:0] win;
        logic [7:0] data;
        logic [7:0] at;
        logic       exp_req;
    } vec_t;

    // Write at count 'at'; exp_req: rst_req expected in the following cycle
    localparam vec_t VECS [12] = '{
        '{3'd0, 2'd0, 8'hAC, 8'd3,  1'b1},  // R4 50% just closed
        '{3'd0, 2'd0, 8'hAC, 8'd4,  1'b0},  // R3/R6 50% boundary open
        '{3'd0, 2'd1, 8'hAC, 8'd1,  1'b1},  // R4 75% closed
        '{3'd0, 2'd1, 8'hAC, 8'd2,  1'b0},  // R6 75% boundary open
        '{3'd0, 2'd2, 8'hAC, 8'd0,  1'b0},  // R7 full window at count 0
        '{3'd0, 2'd3, 8'hAC, 8'd7,  1'b0},  // R7/R3 last cycle before overflow
        '{3'd1, 2'd0, 8'hAC, 8'd7,  1'b1},  // R4 longer period closed
        '{3'd1, 2'd0, 8'hAC, 8'd8,  1'b0},  // R3 longer period open
        '{3'd1, 2'd1, 8'h55, 8'd10, 1'b1},  // R5 wrong value in open window
        '{3'd2, 2'd2, 8'h00, 8'd20, 1'b1},  // R5 zero value, full window
        '{3'd2, 2'd1, 8'hAC, 8'd8,  1'b0},  // R6 75% boundary, H=32
        '{3'd1, 2'd2, 8'hAB, 8'd5,  1'b1}   // R5 near-miss value
    };

    function automatic int span_of(input int sel);
        return 1 << (BASE_EXP + sel + 1);  // R11
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic adv(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int sel, input int win, input logic ien);
        @(negedge clk);
        wr_en          = 1'b0;
        rst_n          = 1'b0;
        cfg_period_sel = SEL_W'(sel);
        cfg_window_sel = 2'(win);
        cfg_irq_en     = ien;
        adv(3);
        check("R1 irq in reset", irq, 1'b0);
        check("R1 rst_req in reset", rst_req, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // Table walk: R3 R4 R5 R6 R7
        foreach (VECS[i]) begin
            vec_t v;
            int   h;
            v = VECS[i];
            h = span_of(int'(v.sel));
            do_reset(int'(v.sel), int'(v.win), 1'b0);
            adv(int'(v.at));
            wr_en   = 1'b1;
            wr_data = v.data;
            adv(1);
            wr_en = 1'b0;
            check("R3/R4/R5 response to write", rst_req, v.exp_req);
            adv(1);
            check("R2 request is single pulse", rst_req, 1'b0);
            adv(h - 2);
            check("R3 count restarted, no early overflow", rst_req, 1'b0);
            adv(1);
            check("R3 overflow H after restart", rst_req, 1'b1);
        end

        // R2 and R11: plain overflow with H=32, twice
        do_reset(2, 2, 1'b0);
        adv(31);
        check("R2 no request before H", rst_req, 1'b0);
        adv(1);
        check("R11 request at H", rst_req, 1'b1);
        check("R9 irq stays low", irq, 1'b0);
        adv(1);
        check("R2 single pulse", rst_req, 1'b0);
        adv(31);
        check("R2 second overflow at 2H", rst_req, 1'b1);

        // R8: interrupt at 3H/4+1 = 13 for H=16, count keeps running
        do_reset(1, 0, 1'b1);
        adv(12);
        check("R8 irq not early", irq, 1'b0);
        adv(1);
        check("R8 irq at 3H/4+1", irq, 1'b1);
        adv(1);
        check("R8 irq single cycle", irq, 1'b0);
        adv(1);
        check("R8 count continues, no request yet", rst_req, 1'b0);
        adv(1);
        check("R8 overflow after interrupt", rst_req, 1'b1);

        // R9: interrupt disabled
        do_reset(1, 0, 1'b0);
        adv(13);
        check("R9 irq disabled", irq, 1'b0);
        adv(3);
        check("R9 overflow unaffected", rst_req, 1'b1);

        // R10: configuration frozen after release (H=8, 50%, irq on)
        do_reset(0, 0, 1'b1);
        cfg_period_sel = 3'd3;
        cfg_window_sel = 2'd2;
        cfg_irq_en     = 1'b0;
        adv(7);
        check("R10 irq still enabled, period still 8", irq, 1'b1);
        adv(1);
        check("R10 overflow at latched period", rst_req, 1'b1);
        wr_en   = 1'b1;
        wr_data = 8'hAC;
        adv(1);
        wr_en = 1'b0;
        check("R10 latched 50% window rejects key at 0", rst_req, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule